// File: doc/BRIEF.md
# Dual Cascadable 8-bit Interval Timer

Two 8-bit up-counters and one free-running prescaler share this block. Each counter counts the ticks of the clock source chosen for it. When the count reaches that timer's match value, the counter returns to zero and a one-cycle interrupt pulse goes out. The interval is therefore the match value times the tick period. A match value of zero stands for a full 256 ticks.

The two timers offer different source menus. Timer 0 can take rising edges from an external pin, and it also has three prescaler taps. Timer 1 can take the match pulses of timer 0, which chains the two into one long-interval timer, and it also has three prescaler taps, one of them the slowest. Software programs the block through a small write port. The usual order is: stop the timer, choose the source, load the match value, then set the run bit.

Top module: `dual_interval_timer`

## Requirements
- R1: After synchronous reset, every register is zero. Both timers and the prescaler are stopped, and both interrupt outputs stay low.
- R2: The prescaler runs only while bit 7 of the run register (address 0) is set. While that bit is clear, a timer that selects a prescaled source never fires.
- R3: Timer 0 has a 2-bit source select, bits 1:0 of address 1. Codes 1, 2 and 3 select ticks at clk/8, clk/32 and clk/128. Consecutive timer 0 pulses are then match x 8, x 32 or x 128 cycles apart.
- R4: Timer 1 has a 2-bit source select, bits 3:2 of address 1. Codes 1, 2 and 3 select clk/8, clk/128 and clk/2048, and give the same match-times-divider spacing.
- R5: With timer 0 source code 0, each rising edge on the external pin advances timer 0 by exactly one. The pin passes through a two-flop synchroniser first. A level held high counts once.
- R6: With timer 1 source code 0, timer 1 counts timer 0 match pulses. Timer 1 fires once for every M0 x M1 timer 0 ticks.
- R7: A match value of 0 gives a period of 256 ticks.
- R8: Clearing a timer's run bit (bit 0 for timer 0, bit 1 for timer 1, address 0) stops that timer and clears its count. After a restart, a full period is needed before the next pulse.
- R9: Each interrupt is a single-cycle pulse on the match-and-restart event. No pulse appears while the timer's run bit is clear.
- R10: Writing a match register (address 2 for timer 0, address 3 for timer 1) while the timer runs leaves the count untouched. The new value applies from the next compare.
- R11: Timer 1 on clk/8 with match 0x50 fires every 640 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 run, 1 source select, 2 match 0, 3 match 1 |
| wr_data | input | 8 | Write data |
| ext_clk_in | input | 1 | Asynchronous external count input for timer 0 |
| irq0 | output | 1 | Timer 0 interrupt pulse |
| irq1 | output | 1 | Timer 1 interrupt pulse |

## Verification
The only way to see a timer's internal state is through the timing of its interrupt pulses. A counter that is off by one, or left uncleared by a stop, shows up as a wrong spacing on the first pulse after the error, within one period. Runs driven from the external pin advance one edge at a time, so the bench can name the exact edge that must produce a pulse. A wrong prescaler tap or a wrong source-select decode shows up as a period that is a fixed factor off, between the first two pulses after the source is chosen.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int NUM_TAPS = 4;

  // Width of the low prescaler bits that must all be ones for tap k to tick.
  function automatic int tap_bits(input int k);
    case (k)
      0:       return 3;   // clk/8
      1:       return 5;   // clk/32
      2:       return 7;   // clk/128
      default: return 11;  // clk/2048
    endcase
  endfunction

  localparam int PRE_W = tap_bits(NUM_TAPS - 1);

  typedef enum logic [1:0] {
    ADDR_RUN = 2'd0,
    ADDR_SEL = 2'd1,
    ADDR_M0  = 2'd2,
    ADDR_M1  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dit_prescaler.sv
module dit_prescaler
  import dit_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  output logic [PRE_W-1:0]    cnt,
  output logic [NUM_TAPS-1:0] tick
);
  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    localparam int W = tap_bits(k);
    assign tick[k] = run && (&cnt[W-1:0]);
  end
endmodule

// File: rtl/dit_edge_sync.sv
module dit_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic rise
);
  logic [2:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[1:0], pin};
  end

  assign rise = sh_q[1] && !sh_q[2];
endmodule

// File: rtl/dit_counter.sv
module dit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] match,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   nxt;
  logic [CNT_W:0]   tgt;

  always_comb begin
    nxt = {1'b0, cnt_q} + 1'b1;
    tgt = (match == '0) ? ((CNT_W+1)'(1) << CNT_W) : {1'b0, match};
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (tick) begin
        if (nxt == tgt) begin
          cnt_q <= '0;
          irq   <= 1'b1;
        end else begin
          cnt_q <= nxt[CNT_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_clk_in,
  output logic             irq0,
  output logic             irq1
);
  localparam int NT = 2;

  logic [NT-1:0]    run_q;
  logic             pre_run_q;
  logic [1:0]       sel_q [NT];
  logic [CNT_W-1:0] match_q [NT];
  logic [NT-1:0]    tick;
  logic [NT-1:0]    irq;
  logic [NUM_TAPS-1:0] ptick;
  logic [PRE_W-1:0]    pre_cnt;
  logic             ext_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      pre_run_q <= 1'b0;
      for (int i = 0; i < NT; i++) begin
        sel_q[i]   <= '0;
        match_q[i] <= '0;
      end
    end else if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        ADDR_RUN: begin
          run_q     <= wr_data[NT-1:0];
          pre_run_q <= wr_data[CNT_W-1];
        end
        ADDR_SEL: begin
          sel_q[0] <= wr_data[1:0];
          sel_q[1] <= wr_data[3:2];
        end
        ADDR_M0: match_q[0] <= wr_data;
        default: match_q[1] <= wr_data;
      endcase
    end
  end

  dit_prescaler u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (pre_run_q),
    .cnt  (pre_cnt),
    .tick (ptick)
  );

  dit_edge_sync u_sync (
    .clk  (clk),
    .rst  (rst),
    .pin  (ext_clk_in),
    .rise (ext_rise)
  );

  // Source menus differ per timer.
  always_comb begin
    case (sel_q[0])
      2'd0:    tick[0] = ext_rise;
      2'd1:    tick[0] = ptick[0];
      2'd2:    tick[0] = ptick[1];
      default: tick[0] = ptick[2];
    endcase
    case (sel_q[1])
      2'd0:    tick[1] = irq[0];
      2'd1:    tick[1] = ptick[0];
      2'd2:    tick[1] = ptick[2];
      default: tick[1] = ptick[3];
    endcase
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    dit_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .run   (run_q[t]),
      .tick  (tick[t]),
      .match (match_q[t]),
      .irq   (irq[t])
    );
  end

  assign irq0 = irq[0];
  assign irq1 = irq[1];
endmodule

// File: rtl/dit_checker.sv
module dit_checker
  import dit_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             irq0,
  input logic             irq1,
  input logic [1:0]       run,
  input logic             pre_run,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [1:0]       tick,
  input logic             ext_rise
);
  assert_prescaler_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !pre_run |=> (pre_cnt == '0));

  assert_irq0_from_tick_R3: assert property (@(posedge clk) disable iff (rst)
    irq0 |-> $past(tick[0]));

  assert_irq1_from_tick_R4: assert property (@(posedge clk) disable iff (rst)
    irq1 |-> $past(tick[1]));

  assert_edge_single_R5: assert property (@(posedge clk) disable iff (rst)
    ext_rise |=> !ext_rise);

  assert_irq0_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    irq0 |=> !irq0);

  assert_irq1_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    irq1 |=> !irq1);

  assert_irq0_running_R9: assert property (@(posedge clk) disable iff (rst)
    irq0 |-> $past(run[0]));

  assert_irq1_running_R9: assert property (@(posedge clk) disable iff (rst)
    irq1 |-> $past(run[1]));
endmodule

bind dual_interval_timer dit_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq0     (irq0),
  .irq1     (irq1),
  .run      (run_q),
  .pre_run  (pre_run_q),
  .pre_cnt  (pre_cnt),
  .tick     (tick),
  .ext_rise (ext_rise)
);

// File: tb/test_dual_interval_timer.sv
module test_dual_interval_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ext_pin = 1'b0;
  logic       irq0, irq1;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  int n0 = 0, n1 = 0, per0 = 0, per1 = 0, last0 = 0, last1 = 0;
  bit multi0 = 0, multi1 = 0, p0 = 0, p1 = 0;

  always #10 clk = ~clk;

  dual_interval_timer i_dual_interval_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_clk_in(ext_pin), .irq0(irq0), .irq1(irq1)
  );

  always @(negedge clk) begin
    cyc++;
    if (irq0) begin n0++; per0 = cyc - last0; last0 = cyc; end
    if (irq1) begin n1++; per1 = cyc - last1; last1 = cyc; end
    if (irq0 && p0) multi0 = 1;
    if (irq1 && p1) multi1 = 1;
    p0 = irq0;
    p1 = irq1;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_edge();
    @(negedge clk) ext_pin = 1'b1;
    idle(3);
    ext_pin = 1'b0;
    idle(4);
  endtask

  task automatic period_of(input bit which, output int p);
    int base = which ? n1 : n0;
    int t = 0;
    while (((which ? n1 : n0) < base + 2) && t < 20000) begin
      @(negedge clk);
      t++;
    end
    p = (t >= 20000) ? 0 : (which ? per1 : per0);
  endtask

  task automatic t_reset();
    int b0, b1;
    rst = 1'b1; idle(4);
    chk("R1 irq0 in reset", irq0, 0);
    chk("R1 irq1 in reset", irq1, 0);
    rst = 1'b0; idle(2);
    b0 = n0; b1 = n1;
    wr(0, 8'h80);  // prescaler only, timers idle
    idle(600);
    chk("R1 timer0 idle after reset", n0 - b0, 0);
    chk("R1 timer1 idle after reset", n1 - b1, 0);
  endtask

  task automatic t_prescaler_off();
    int b0, b1, p;
    wr(0, 8'h00);
    wr(1, 8'h05);   // both on clk/8
    wr(2, 8'd1);
    wr(3, 8'd1);
    b0 = n0; b1 = n1;
    wr(0, 8'h03);   // timers run, prescaler off
    idle(300);
    chk("R2 timer0 silent prescaler off", n0 - b0, 0);
    chk("R2 timer1 silent prescaler off", n1 - b1, 0);
    wr(0, 8'h83);
    period_of(0, p); chk("R2 timer0 after prescaler on", p, 8);
    period_of(1, p); chk("R2 timer1 after prescaler on", p, 8);
  endtask

  task automatic t_stopped_quiet();
    int b0;
    wr(0, 8'h80);
    b0 = n0;
    idle(300);
    chk("R9 no pulse while stopped", n0 - b0, 0);
  endtask

  task automatic t_t0_periods();
    int p;
    wr(0, 8'h00); wr(1, 8'h01); wr(2, 8'd4); wr(0, 8'h81);
    period_of(0, p); chk("R3 timer0 clk/8 m4", p, 32);
    wr(0, 8'h00); wr(1, 8'h02); wr(2, 8'd3); wr(0, 8'h81);
    period_of(0, p); chk("R3 timer0 clk/32 m3", p, 96);
    wr(0, 8'h00); wr(1, 8'h03); wr(2, 8'd2); wr(0, 8'h81);
    period_of(0, p); chk("R3 timer0 clk/128 m2", p, 256);
  endtask

  task automatic t_t1_periods();
    int p;
    wr(0, 8'h00); wr(1, 8'h04); wr(3, 8'd5); wr(0, 8'h82);
    period_of(1, p); chk("R4 timer1 clk/8 m5", p, 40);
    wr(0, 8'h00); wr(1, 8'h08); wr(3, 8'd3); wr(0, 8'h82);
    period_of(1, p); chk("R4 timer1 clk/128 m3", p, 384);
    wr(0, 8'h00); wr(1, 8'h0C); wr(3, 8'd1); wr(0, 8'h82);
    period_of(1, p); chk("R4 timer1 clk/2048 m1", p, 2048);
  endtask

  task automatic t_match_zero();
    int p;
    wr(0, 8'h00); wr(1, 8'h01); wr(2, 8'd0); wr(0, 8'h81);
    period_of(0, p); chk("R7 match 0 is 256 ticks", p, 2048);
  endtask

  task automatic t_example();
    int p;
    wr(0, 8'h00); wr(1, 8'h04); wr(3, 8'h50); wr(0, 8'h82);
    period_of(1, p); chk("R11 0x50 on clk/8", p, 640);
  endtask

  task automatic t_ext();
    int b0;
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'd3);
    b0 = n0;
    wr(0, 8'h01);
    @(negedge clk) ext_pin = 1'b1;   // long high level counts once
    idle(20);
    ext_pin = 1'b0;
    idle(5);
    ext_edge();
    chk("R5 two edges no pulse", n0 - b0, 0);
    ext_edge();
    chk("R5 third edge fires", n0 - b0, 1);
  endtask

  task automatic t_stop_clear();
    int b0;
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'd5); wr(0, 8'h01);
    repeat (3) ext_edge();
    wr(0, 8'h00);
    wr(0, 8'h01);
    b0 = n0;
    repeat (4) ext_edge();
    chk("R8 count cleared by stop", n0 - b0, 0);
    ext_edge();
    chk("R8 full period after restart", n0 - b0, 1);
  endtask

  task automatic t_match_write();
    int b0;
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'd10); wr(0, 8'h01);
    b0 = n0;
    repeat (3) ext_edge();
    wr(2, 8'd5);
    ext_edge();
    chk("R10 count kept after write", n0 - b0, 0);
    ext_edge();
    chk("R10 new match at next compare", n0 - b0, 1);
    repeat (5) ext_edge();
    chk("R10 new match keeps period", n0 - b0, 2);
  endtask

  task automatic t_cascade();
    int b0, b1;
    wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'd3); wr(3, 8'd4);
    b0 = n0; b1 = n1;
    wr(0, 8'h03);
    repeat (11) ext_edge();
    chk("R6 cascade not yet", n1 - b1, 0);
    ext_edge();
    chk("R6 cascade fires at 12 edges", n1 - b1, 1);
    chk("R6 timer0 pulses feeding", n0 - b0, 4);
  endtask

  initial begin
    t_reset();
    t_prescaler_off();
    t_stopped_quiet();
    t_t0_periods();
    t_t1_periods();
    t_match_zero();
    t_example();
    t_ext();
    t_stop_clear();
    t_match_write();
    t_cascade();
    chk("R9 irq0 single-cycle", multi0, 0);
    chk("R9 irq1 single-cycle", multi1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule